// File: doc/BRIEF.md
# Timed Random Byte Source

This peripheral produces one fresh 8-bit random byte at a time on a fixed cadence. A start task arms it and a stop task halts it. Either task can come from a register write or from a hardware input level. Once active, the block waits one generation period, latches a byte, raises a sticky ready flag and emits a one-cycle ready pulse. It then either re-arms for the next byte or stops on its own, depending on an auto-halt bit. The period is longer when a bias-correction mode bit is set, and both periods are given in microseconds and converted to clock cycles.

The entropy source is a free-running 32-bit Galois LFSR, so every byte can be predicted from the cycle count since reset. The interrupt line is the AND of an enable bit and the ready flag. Software reaches the enable bit through a direct register, a set register and a clear register. Accesses are 32-bit only, over a simple valid/write/address/data bus whose reads are combinational.

Top module: `rng_periph`

## Requirements
- R1: Writing exactly 1 to offset 0x000 (start task) makes the block active and restarts the period count; a write of any other value has no effect. The first byte is latched P clock edges after the write edge.
- R2: Writing 1 to offset 0x004 (stop task) makes the block inactive and discards the pending byte. If start and stop arrive in the same cycle, stop wins.
- R3: At each period expiry the byte register (offset 0x508, bits 7:0) loads bits 7:0 of the LFSR as they were just before that edge. On the same edge the ready flag sets, and `ready_pulse_o` goes high for exactly one cycle.
- R4: P is RAW_US*CLK_MHZ cycles when bit 0 of the mode register (offset 0x504) is 0, and FILT_US*CLK_MHZ cycles when it is 1.
- R5: With bit 0 of the auto-halt register (offset 0x200) set, the block goes inactive after producing one byte. With it clear, bytes keep coming every P cycles.
- R6: `irq_o` is high exactly when the interrupt enable and the ready flag are both 1.
- R7: A write of 0 to the flag register (offset 0x100) clears the ready flag, and a nonzero write leaves it unchanged. Reading offset 0x100 returns the flag in bit 0.
- R8: The interrupt enable can be written directly through bit 0 of offset 0x300. Writing 1 in bit 0 of 0x304 sets it, and writing 1 in bit 0 of 0x308 clears it. A read of any of the three offsets returns the enable in bit 0.
- R9: Each cycle that `hw_start_i` is high acts as a start task, and each cycle that `hw_stop_i` is high acts as a stop task.
- R10: After reset the byte, the active state, the flag, the auto-halt bit, the enable and the mode bit are all 0, and no byte is pending.
- R11: Reads of unmapped offsets and of the two task offsets return 0. Writes to unmapped offsets change nothing.
- R12: The LFSR resets to LFSR_SEED. On every clock edge out of reset it steps as s = (s >> 1) XOR (s[0] ? 0x80200003 : 0).
- R13: A start task while already active restarts the count, so the next byte comes P cycles after the later start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| hw_start_i | input | 1 | Hardware start task level |
| hw_stop_i | input | 1 | Hardware stop task level |
| ready_pulse_o | output | 1 | One-cycle pulse per new byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong period count or a missed re-arm shows up as a ready pulse on the wrong cycle. That is caught the first time a pulse is expected, within one period. A stale active state shows up as a pulse that no one expected, or as a byte that never comes. A wrong LFSR state or a wrong sampling edge shows up as a byte mismatch on the first read after any expiry. Flag and enable faults show up at once on `irq_o` or on the next read of the register.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_GO     = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_HALT   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_FLAG   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_AUTO   = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_ISET   = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_ICLR   = 12'h308;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 12'h508;

  function automatic logic [31:0] galois_step(input logic [31:0] s, input logic [31:0] taps);
    return s[0] ? ((s >> 1) ^ taps) : (s >> 1);
  endfunction

  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned mhz);
    return us * mhz;
  endfunction
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter logic [31:0] SEED = 32'hACE1_2468,
  parameter logic [31:0] TAPS = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] state_o
);
  import rng_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) state_o <= SEED;
    else        state_o <= galois_step(state_o, TAPS);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 32'd0); // R12
endmodule

// File: rtl/rng_cadence.sv
module rng_cadence #(
  parameter int unsigned RAW_CYC  = 167,
  parameter int unsigned FILT_CYC = 660,
  localparam int unsigned MAX_CYC = (FILT_CYC > RAW_CYC) ? FILT_CYC : RAW_CYC,
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic arm_i,
  input  logic filt_i,
  output logic fire_o
);
  localparam logic [CNT_W-1:0] RAW_LAST  = CNT_W'(RAW_CYC - 1);
  localparam logic [CNT_W-1:0] FILT_LAST = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last   = filt_i ? FILT_LAST : RAW_LAST;
  assign fire_o = run_i && !arm_i && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (arm_i || !run_i || fire_o) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !fire_o); // R2
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> cnt == '0); // R13
endmodule

// File: rtl/rng_periph.sv
module rng_periph #(
  parameter int unsigned CLK_MHZ   = 16,
  parameter int unsigned RAW_US    = 167,
  parameter int unsigned FILT_US   = 660,
  parameter logic [31:0] LFSR_SEED = 32'hACE1_2468,
  parameter logic [31:0] LFSR_TAPS = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        hw_start_i,
  input  logic        hw_stop_i,
  output logic        ready_pulse_o,
  output logic        irq_o
);
  import rng_pkg::*;

  localparam int unsigned RAW_CYC  = us_to_cycles(RAW_US, CLK_MHZ);
  localparam int unsigned FILT_CYC = us_to_cycles(FILT_US, CLK_MHZ);

  logic        run, flag, auto_halt, ien, filt;
  logic [7:0]  sample;
  logic [31:0] lfsr;
  logic        wr, start_any, stop_any, fire;

  assign wr        = bus_valid && bus_write;
  assign start_any = (wr && bus_addr == OFS_GO   && bus_wdata == 32'd1) || hw_start_i;
  assign stop_any  = (wr && bus_addr == OFS_HALT && bus_wdata == 32'd1) || hw_stop_i;

  rng_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state_o(lfsr)
  );

  rng_cadence #(.RAW_CYC(RAW_CYC), .FILT_CYC(FILT_CYC)) u_cadence (
    .clk(clk), .rst_n(rst_n), .run_i(run), .arm_i(start_any),
    .filt_i(filt), .fire_o(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run           <= 1'b0;
      flag          <= 1'b0;
      auto_halt     <= 1'b0;
      ien           <= 1'b0;
      filt          <= 1'b0;
      sample        <= 8'd0;
      ready_pulse_o <= 1'b0;
    end else begin
      ready_pulse_o <= fire;
      if (fire) sample <= lfsr[7:0];

      if (stop_any)                run <= 1'b0;
      else if (start_any)          run <= 1'b1;
      else if (fire && auto_halt)  run <= 1'b0;

      if (fire)                                                flag <= 1'b1;
      else if (wr && bus_addr == OFS_FLAG && bus_wdata == '0)  flag <= 1'b0;

      if (wr && bus_addr == OFS_AUTO) auto_halt <= bus_wdata[0];
      if (wr && bus_addr == OFS_MODE) filt      <= bus_wdata[0];

      if (wr && bus_addr == OFS_IEN)                       ien <= bus_wdata[0];
      else if (wr && bus_addr == OFS_ISET && bus_wdata[0]) ien <= 1'b1;
      else if (wr && bus_addr == OFS_ICLR && bus_wdata[0]) ien <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        OFS_FLAG:                     bus_rdata = {31'd0, flag};
        OFS_AUTO:                     bus_rdata = {31'd0, auto_halt};
        OFS_IEN, OFS_ISET, OFS_ICLR:  bus_rdata = {31'd0, ien};
        OFS_MODE:                     bus_rdata = {31'd0, filt};
        OFS_SAMPLE:                   bus_rdata = {24'd0, sample};
        default:                      bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = ien && flag;

  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse_o |-> $past(run)); // R1
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse_o |=> !ready_pulse_o); // R3
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse_o |-> flag); // R3
  AST_SAMPLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_pulse_o |-> $stable(sample)); // R3
  AST_AUTO_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_pulse_o && $past(auto_halt) && !$past(start_any)) |-> !run); // R5
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_any |=> !run); // R2
endmodule

// File: tb/test_rng_periph.sv
module test_rng_periph;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 1;
  localparam int RAW = 167;
  localparam int FILT = 660;
  localparam logic [31:0] SEED = 32'hACE1_2468;
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic hw_start = 0, hw_stop = 0;
  logic pulse, irq;

  int checks = 0, fails = 0, cyc = 0, npulse = 0;
  int exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_periph #(.CLK_MHZ(MHZ), .RAW_US(RAW), .FILT_US(FILT), .LFSR_SEED(SEED), .LFSR_TAPS(TAPS)) i_rng_periph (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_start_i(hw_start), .hw_stop_i(hw_stop), .ready_pulse_o(pulse), .irq_o(irq)
  );

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic logic [7:0] byte_at(int n);
    logic [31:0] s = SEED;
    for (int i = 0; i < n; i++) s = (s >> 1) ^ ({32{s[0]}} & TAPS);
    return s[7:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected pulse cycles
  always @(negedge clk) begin
    if (rst_n && pulse) begin
      npulse++;
      if (exp_q.size() == 0) check("R3 unexpected pulse", 32'(cyc), 32'hFFFF_FFFF);
      else check("R4 pulse cycle", 32'(cyc), 32'(exp_q.pop_front()));
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d, output int edge_cyc);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    edge_cyc = cyc;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int e0, e1, np;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    bus_rd(12'h508, rd); check("R10 sample", rd, 0);
    bus_rd(12'h100, rd); check("R10 flag", rd, 0);
    bus_rd(12'h200, rd); check("R10 auto", rd, 0);
    bus_rd(12'h300, rd); check("R10 ien", rd, 0);
    bus_rd(12'h504, rd); check("R10 mode", rd, 0);
    check("R10 irq", irq, 0);
    check("R10 pulse", pulse, 0);

    // R1 R5 R12 single byte with auto-halt, raw period
    bus_wr(12'h200, 1, e0);
    bus_wr(12'h000, 1, e0);
    exp_q.push_back(e0 + RAW);
    wait_until(e0 + RAW + 2);
    bus_rd(12'h508, rd); check("R3 R12 byte", rd, {24'd0, byte_at(e0 + RAW - 1)});
    bus_rd(12'h100, rd); check("R7 flag set", rd, 1);
    check("R6 irq disabled", irq, 0);
    repeat (400) @(negedge clk);
    check("R5 halted after one", 32'(npulse), 1);

    // R6 R7 R8 interrupt enable paths and flag clear
    bus_wr(12'h304, 1, e0); check("R8 set -> R6 irq", irq, 1);
    bus_rd(12'h308, rd); check("R8 read via clr", rd, 1);
    bus_wr(12'h308, 1, e0); check("R8 clr -> irq", irq, 0);
    bus_wr(12'h300, 1, e0); check("R8 direct", irq, 1);
    bus_wr(12'h304, 2, e0); bus_rd(12'h300, rd); check("R8 set bit1 only", rd, 1);
    bus_wr(12'h100, 5, e0); check("R7 nonzero keeps flag", irq, 1);
    bus_wr(12'h100, 0, e0); check("R7 zero clears flag", irq, 0);
    bus_rd(12'h100, rd); check("R7 flag read", rd, 0);

    // R4 R5 continuous, filtered period
    bus_wr(12'h504, 1, e0);
    bus_wr(12'h200, 0, e0);
    bus_wr(12'h000, 1, e0);
    exp_q.push_back(e0 + FILT);
    exp_q.push_back(e0 + 2*FILT);
    wait_until(e0 + 2*FILT + 1);
    bus_rd(12'h508, rd); check("R4 R12 second byte", rd, {24'd0, byte_at(e0 + 2*FILT - 1)});
    check("R6 irq with flag", irq, 1);
    bus_wr(12'h004, 1, e0);
    np = npulse;
    repeat (800) @(negedge clk);
    check("R2 stop halts", 32'(npulse), 32'(np));

    // R1 non-1 start ignored
    bus_wr(12'h504, 0, e0);
    bus_wr(12'h200, 1, e0);
    bus_wr(12'h000, 2, e0);
    repeat (300) @(negedge clk);
    check("R1 start value 2 ignored", 32'(npulse), 32'(np));

    // R9 hardware start and stop
    @(negedge clk); hw_start = 1;
    @(negedge clk); hw_start = 0; e0 = cyc;
    exp_q.push_back(e0 + RAW);
    wait_until(e0 + RAW + 2);
    check("R9 hw start pulse", 32'(npulse), 32'(np + 1));
    np = npulse;
    bus_wr(12'h000, 1, e0);
    repeat (50) @(negedge clk);
    hw_stop = 1; @(negedge clk); hw_stop = 0;
    repeat (300) @(negedge clk);
    check("R9 hw stop", 32'(npulse), 32'(np));

    // R2 start and stop same cycle: stop wins
    @(negedge clk); hw_start = 1; hw_stop = 1;
    @(negedge clk); hw_start = 0; hw_stop = 0;
    repeat (300) @(negedge clk);
    check("R2 stop beats start", 32'(npulse), 32'(np));

    // R13 restart while active
    bus_wr(12'h000, 1, e0);
    repeat (100) @(negedge clk);
    bus_wr(12'h000, 1, e1);
    exp_q.push_back(e1 + RAW);
    wait_until(e1 + RAW + 2);
    check("R13 restart one pulse", 32'(npulse), 32'(np + 1));
    bus_rd(12'h508, rd); check("R13 byte", rd, {24'd0, byte_at(e1 + RAW - 1)});

    // R11 unmapped access
    bus_rd(12'h010, rd); check("R11 unmapped read", rd, 0);
    bus_rd(12'h000, rd); check("R11 task read", rd, 0);
    bus_wr(12'h400, 32'hFFFF_FFFF, e0);
    bus_rd(12'h504, rd); check("R11 mode untouched", rd, 0);
    bus_rd(12'h300, rd); check("R11 ien untouched", rd, 1);

    check("R5 queue drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule